// File: doc/BRIEF.md
# Memory Map Decoder with Boot Overlay

This block turns the 16-bit address of an 8-bit processor bus into one-hot, active-high chip selects. The targets are a 64K boot ROM, a 64K RAM and ten peripheral windows. Both memories span the whole address space except one reserved page. That page, `IO_PAGE` (default $FC), is always routed to the peripheral windows.

From reset the decoder runs a boot overlay: memory reads come from ROM while memory writes land in RAM. This lets start-up code copy itself into RAM. A read anywhere in the function-latch window sets a one-way flag that takes the ROM out of the map. From then on every memory read is served by RAM, and only a reset brings the ROM back.

A write to the same window loads the clock-access enable. This is the bit at position `CLK_EN_BIT` (default 3) of the write data. The decoder keeps its own copy of it and gates the two clock-chip windows with it. Reads in the unused part of the page select nothing and raise an idle-bus indication instead.

Top module: `memmap_decoder`

## Requirements
- R1: With `valid` high and `addr[15:8]` equal to `IO_PAGE`, neither `sel_rom` nor `sel_ram` is asserted, for reads and writes alike.
- R2: After reset, a valid read (`rd` = 1) outside the I/O page asserts `sel_rom` only, and a valid write (`rd` = 0) outside the I/O page asserts `sel_ram` only.
- R3: A valid read of offsets $08-$0B in the I/O page sets the ROM-off flag on that clock edge. From the next cycle, valid reads outside the I/O page assert `sel_ram`, not `sel_rom`.
- R4: Once set, the ROM-off flag stays set through any further accesses. Only a synchronous reset (`rst` = 1 at a clock edge) clears it, after which reads select ROM again.
- R5: Page offsets decode as follows. $10-$1F gives `sel_via`. $0C-$0F gives `sel_disk`. $2C-$2F gives `sel_door`. $20-$23 gives `sel_net`. $30-$33 gives `sel_scsi`. $08-$0B gives `sel_func`. $24-$27 gives `sel_net_irq_off`. $28-$2B gives `sel_net_irq_on`. Each of these applies to both reads and writes.
- R6: A valid write to offsets $08-$0B loads `wdata[CLK_EN_BIT]` into the clock enable, and reset clears the enable to 0. Offsets $00-$03 assert `sel_rtc_addr` and offsets $04-$07 assert `sel_rtc_data`, but only while the enable is 1. While it is 0, those offsets assert no output.
- R7: A write to offsets $08-$0B does not set the ROM-off flag.
- R8: Offsets $34-$FF assert no select. A valid read there asserts `bus_idle`, while a write there leaves it low.
- R9: At most one of the twelve select outputs is high in any cycle. All selects and `bus_idle` are low whenever `valid` is low.
- R10: A read of offsets $08-$0B with `valid` low does not set the ROM-off flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Bus cycle qualifier |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Bus address |
| wdata | input | DATA_W | Write data, sampled for the function latch |
| sel_rom | output | 1 | Boot ROM select |
| sel_ram | output | 1 | RAM select |
| sel_rtc_addr | output | 1 | Clock chip address register select |
| sel_rtc_data | output | 1 | Clock chip data register select |
| sel_func | output | 1 | Function latch select |
| sel_disk | output | 1 | Disk controller select |
| sel_via | output | 1 | Parallel port interface select |
| sel_net | output | 1 | Network controller select |
| sel_net_irq_off | output | 1 | Network interrupt disable strobe |
| sel_net_irq_on | output | 1 | Network interrupt enable strobe |
| sel_door | output | 1 | Door switch status select |
| sel_scsi | output | 1 | SCSI interface select |
| bus_idle | output | 1 | Read of an unmapped I/O offset |

## Verification
The embedded assertions check on every cycle the properties that hold regardless of history. These are the one-hot selects, silence while `valid` is low, the I/O page being carved out of both memories, writes never reaching ROM, and the ROM-off flag never dropping without reset. Other behaviour needs a sequence of accesses, so only the directed scenarios can show it. This covers the exact window edges across all 256 page offsets, the overlay switching on a function-window read but not on a write or an unqualified read, the clock enable following written data, and reset bringing the ROM back.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter logic [7:0] IO_PAGE    = 8'hFC,
  parameter int         DATA_W     = 8,
  parameter int         CLK_EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              rd,
  input  logic [15:0]       addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_rom,
  output logic              sel_ram,
  output logic              sel_rtc_addr,
  output logic              sel_rtc_data,
  output logic              sel_func,
  output logic              sel_disk,
  output logic              sel_via,
  output logic              sel_net,
  output logic              sel_net_irq_off,
  output logic              sel_net_irq_on,
  output logic              sel_door,
  output logic              sel_scsi,
  output logic              bus_idle
);

  logic       rom_off;
  logic       clk_en;
  logic       in_page;
  logic [7:0] off;
  logic [5:0] quad;

  assign in_page = valid && (addr[15:8] == IO_PAGE);
  assign off     = addr[7:0];
  assign quad    = off[7:2];

  assign sel_rom = valid && !in_page && rd && !rom_off;
  assign sel_ram = valid && !in_page && (!rd || rom_off);

  assign sel_rtc_addr    = in_page && quad == 6'd0 && clk_en;
  assign sel_rtc_data    = in_page && quad == 6'd1 && clk_en;
  assign sel_func        = in_page && quad == 6'd2;
  assign sel_disk        = in_page && quad == 6'd3;
  assign sel_via         = in_page && off[7:4] == 4'h1;
  assign sel_net         = in_page && quad == 6'd8;
  assign sel_net_irq_off = in_page && quad == 6'd9;
  assign sel_net_irq_on  = in_page && quad == 6'd10;
  assign sel_door        = in_page && quad == 6'd11;
  assign sel_scsi        = in_page && quad == 6'd12;
  assign bus_idle        = in_page && rd && off >= 8'h34;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_off <= 1'b0;
      clk_en  <= 1'b0;
    end else if (sel_func) begin
      if (rd) rom_off <= 1'b1;
      else    clk_en  <= wdata[CLK_EN_BIT];
    end
  end

  logic [11:0] sels;
  assign sels = {sel_rom, sel_ram, sel_rtc_addr, sel_rtc_data, sel_func, sel_disk,
                 sel_via, sel_net, sel_net_irq_off, sel_net_irq_on, sel_door, sel_scsi};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(sels)); // R9
  AST_QUIET_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (sels == 12'd0 && !bus_idle)); // R9
  AST_PAGE_NOT_MEM: assert property (@(posedge clk) disable iff (rst)
    (valid && addr[15:8] == IO_PAGE) |-> (!sel_rom && !sel_ram)); // R1
  AST_WRITE_NOT_ROM: assert property (@(posedge clk) disable iff (rst)
    (valid && !rd) |-> !sel_rom); // R2
  AST_ROM_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    rom_off |=> rom_off); // R4
  AST_ROM_OFF_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (sel_func && rd) |=> !sel_rom); // R3
  AST_IDLE_ONLY_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> (sels == 12'd0 && rd)); // R8

endmodule

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;
  logic clk = 0, rst = 1, valid = 0, rd = 1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic sel_rom, sel_ram, sel_rtc_addr, sel_rtc_data, sel_func, sel_disk, sel_via;
  logic sel_net, sel_net_irq_off, sel_net_irq_on, sel_door, sel_scsi, bus_idle;
  int total = 0, bad = 0;
  logic m_off = 0, m_en = 0;

  always #2 clk = ~clk;

  memmap_decoder uut (.clk(clk), .rst(rst), .valid(valid), .rd(rd), .addr(addr),
    .wdata(wdata), .sel_rom(sel_rom), .sel_ram(sel_ram), .sel_rtc_addr(sel_rtc_addr),
    .sel_rtc_data(sel_rtc_data), .sel_func(sel_func), .sel_disk(sel_disk),
    .sel_via(sel_via), .sel_net(sel_net), .sel_net_irq_off(sel_net_irq_off),
    .sel_net_irq_on(sel_net_irq_on), .sel_door(sel_door), .sel_scsi(sel_scsi),
    .bus_idle(bus_idle));

  // bit order: rom ram rtca rtcd func disk via net ioff ion door scsi idle
  function automatic logic [12:0] expect_sel(input logic v, input logic r, input logic [15:0] a);
    logic [12:0] e = 13'd0;
    logic [7:0] o = a[7:0];
    if (!v) return e;
    if (a[15:8] != 8'hFC) begin
      if (r && !m_off) e[12] = 1; else e[11] = 1;
    end else if (o <= 8'h03) e[10] = m_en;
    else if (o <= 8'h07) e[9] = m_en;
    else if (o <= 8'h0B) e[8] = 1;
    else if (o <= 8'h0F) e[7] = 1;
    else if (o <= 8'h1F) e[6] = 1;
    else if (o <= 8'h23) e[5] = 1;
    else if (o <= 8'h27) e[4] = 1;
    else if (o <= 8'h2B) e[3] = 1;
    else if (o <= 8'h2F) e[2] = 1;
    else if (o <= 8'h33) e[1] = 1;
    else e[0] = r;
    return e;
  endfunction

  task automatic access(input logic v, input logic r, input logic [15:0] a,
                        input logic [7:0] d, input string tag);
    logic [12:0] got, exp;
    @(negedge clk);
    valid = v; rd = r; addr = a; wdata = d;
    #1;
    exp = expect_sel(v, r, a);
    got = {sel_rom, sel_ram, sel_rtc_addr, sel_rtc_data, sel_func, sel_disk, sel_via,
           sel_net, sel_net_irq_off, sel_net_irq_on, sel_door, sel_scsi, bus_idle};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h rd=%b valid=%b actual=%b expected=%b", tag, a, r, v, got, exp);
    end
    @(posedge clk);
    if (v && a[15:8] == 8'hFC && a[7:2] == 6'd2) begin
      if (r) m_off = 1; else m_en = d[3];
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1; valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0; m_off = 0; m_en = 0;
  endtask

  task automatic t_reset_quiet;
    access(0, 1, 16'h1000, 0, "R9 quiet");
    access(0, 0, 16'hFC08, 0, "R9 quiet");
    access(0, 1, 16'hFC40, 0, "R9 quiet");
  endtask

  task automatic t_overlay_on;
    foreach (bootaddrs[i]) begin
      access(1, 1, bootaddrs[i], 0, "R2 read rom");
      access(1, 0, bootaddrs[i], 0, "R2 write ram");
    end
  endtask
  logic [15:0] bootaddrs [5] = '{16'h0000, 16'h8000, 16'hFBFF, 16'hFD00, 16'hFFFF};

  task automatic t_func_write;
    access(1, 0, 16'hFC08, 8'h08, "R7 func write");
    access(1, 1, 16'h4000, 0, "R7 rom kept");
    access(1, 1, 16'hFC00, 0, "R6 clock on");
    access(1, 0, 16'hFC07, 0, "R6 clock on");
    access(1, 0, 16'hFC0B, 8'hF7, "R6 clear en");
    access(1, 1, 16'hFC03, 0, "R6 clock gated");
    access(1, 1, 16'hFC04, 0, "R6 clock gated");
    access(0, 1, 16'hFC09, 0, "R10 invalid read");
    access(1, 1, 16'h4000, 0, "R10 rom kept");
  endtask

  task automatic t_page_sweep(input logic [7:0] d);
    for (int i = 0; i < 256; i++) begin
      access(1, 0, 16'hFC00 | 16'(i), d, "R5 R8 R1 write sweep");
      access(1, 1, 16'hFC00 | 16'(i), 0, "R5 R8 R1 read sweep");
    end
  endtask

  task automatic t_overlay_off;
    access(1, 1, 16'hFC0A, 0, "R3 trigger");
    access(1, 1, 16'h0000, 0, "R3 ram read");
    access(1, 1, 16'hFFFF, 0, "R3 ram read");
    access(1, 0, 16'h1234, 0, "R4 ram write");
    access(1, 0, 16'hFC08, 8'h00, "R4 still off");
    access(1, 1, 16'hFBFF, 0, "R4 still off");
  endtask

  task automatic t_reset_restore;
    do_reset();
    access(1, 1, 16'h2000, 0, "R4 rom restored");
    access(1, 1, 16'hFC00, 0, "R6 en cleared");
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_quiet();
    t_overlay_on();
    t_func_write();
    t_page_sweep(8'h00);
    t_overlay_off();
    t_reset_restore();
    t_overlay_on();
    t_page_sweep(8'h08);
    t_reset_restore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule